// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounder

This block performs the rounding stage of a floating-point result path. It takes an unrounded mantissa that carries two extra low-order bits (guard above round), a separate sticky bit, the sign of the result and a two-bit rounding-mode code. It drops the two extra bits, adds one at the new least significant position when the selected mode requires it, and reports whether it rounded up and whether the result was inexact.

For every mode and sign, it also decides whether an overflow of the surrounding format should saturate to infinity or to the largest finite magnitude. An increment that overflows the mantissa width is exported as a carry bit. The caller handles exponent adjustment and renormalisation. All outputs are registered, so results appear one clock after the inputs are presented. A synchronous active-high reset clears them.

Top module: `mant_rounder`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is zero after that edge.
- R2: When guard (`mant_i[1]`), round (`mant_i[0]`) and sticky are all zero, the result is exact. `mant_o` equals `mant_i[MANT_W+1:2]`, and `inexact_o`, `rounded_up_o` and `carry_o` are 0.
- R3: `inexact_o` is 1 exactly when guard, round or sticky is 1, whatever the mode.
- R4: In nearest mode (`mode_i` = 00), there is no increment when guard is 0. When guard is 1 and round or sticky is 1, the block increments.
- R5: In nearest mode, guard 1 with round and sticky both 0 is a tie. The block increments only when the truncated mantissa's LSB (`mant_i[2]`) is 1, which rounds ties to even.
- R6: In toward-zero mode (`mode_i` = 01), the block never increments.
- R7: In toward-plus mode (`mode_i` = 10), the block increments exactly when the value is inexact and `sign_i` is 0. In toward-minus mode (`mode_i` = 11), it increments exactly when the value is inexact and `sign_i` is 1.
- R8: `{carry_o, mant_o}` equals the truncated mantissa plus `rounded_up_o`, with full carry propagation. `carry_o` is 1 only when an all-ones truncated mantissa is incremented, and `mant_o` is then zero.
- R9: `ovf_inf_o` is 1 in nearest mode and 0 in toward-zero mode. It equals the inverted sign in toward-plus mode and the sign in toward-minus mode.
- R10: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sign_i | input | 1 | Sign of the value being rounded (1 = negative) |
| mode_i | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward plus, 11 toward minus |
| mant_i | input | MANT_W+2 | Unrounded mantissa; bit 1 guard, bit 0 round |
| sticky_i | input | 1 | OR of all bits below the round bit |
| mant_o | output | MANT_W | Rounded mantissa |
| carry_o | output | 1 | Carry out of the increment |
| rounded_up_o | output | 1 | An increment was applied |
| inexact_o | output | 1 | Guard, round or sticky was nonzero |
| ovf_inf_o | output | 1 | Overflow saturates to infinity (1) or to the largest finite value (0) |

## Verification
A wrong increment decision shows up at the next clock edge in two places. `rounded_up_o` flips, and `mant_o` is off by one at its LSB. A break in the carry chain only shows when a run of ones is incremented, so the sweep includes the all-ones mantissa, which must produce a zero mantissa with `carry_o` set on the following edge. A wrong mode decode flips `ovf_inf_o` within one cycle, even for exact inputs, because that output depends only on mode and sign.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_POS     = 2'b10,
    RM_NEG     = 2'b11
  } round_mode_e;

  localparam int EXTRA_BITS = 2;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  round_mode_e mode,
  input  logic        sign,
  input  logic        guard,
  input  logic        rbit,
  input  logic        sticky,
  input  logic        lsb,
  output logic        inc,
  output logic        inexact
);

  logic below_half;
  logic tie;

  // Any discarded weight makes the result inexact.
  assign inexact    = guard | rbit | sticky;
  assign below_half = rbit | sticky;
  assign tie        = guard & ~below_half;

  always_comb begin
    inc = 1'b0;
    unique case (mode)
      RM_NEAREST: inc = guard & (below_half | (tie & lsb));
      RM_ZERO:    inc = 1'b0;
      RM_POS:     inc = inexact & ~sign;
      RM_NEG:     inc = inexact & sign;
      default:    inc = 1'b0;
    endcase
  end

endmodule

// File: rtl/rnd_ovf_policy.sv
module rnd_ovf_policy
  import rnd_pkg::*;
(
  input  round_mode_e mode,
  input  logic        sign,
  output logic        to_inf
);

  always_comb begin
    to_inf = 1'b1;
    unique case (mode)
      RM_NEAREST: to_inf = 1'b1;
      RM_ZERO:    to_inf = 1'b0;
      RM_POS:     to_inf = ~sign;
      RM_NEG:     to_inf = sign;
      default:    to_inf = 1'b1;
    endcase
  end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int W = 24
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] c;

  assign c[0] = cin;

  // Half-adder chain: the increment only ever adds a single LSB.
  for (genvar i = 0; i < W; i++) begin : g_ha
    assign sum[i] = a[i] ^ c[i];
    assign c[i+1] = a[i] & c[i];
  end

  assign cout = c[W];

endmodule

// File: rtl/mant_rounder.sv
module mant_rounder
  import rnd_pkg::*;
#(
  parameter int MANT_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sign_i,
  input  logic [1:0]        mode_i,
  input  logic [MANT_W+1:0] mant_i,
  input  logic              sticky_i,
  output logic [MANT_W-1:0] mant_o,
  output logic              carry_o,
  output logic              rounded_up_o,
  output logic              inexact_o,
  output logic              ovf_inf_o
);

  localparam int IN_W = MANT_W + EXTRA_BITS;

  round_mode_e       mode;
  logic [MANT_W-1:0] trunc;
  logic              guard;
  logic              rbit;
  logic              inc;
  logic              inexact;
  logic              to_inf;
  logic [MANT_W-1:0] sum;
  logic              cout;

  assign mode  = round_mode_e'(mode_i);
  assign trunc = mant_i[IN_W-1:EXTRA_BITS];
  assign guard = mant_i[1];
  assign rbit  = mant_i[0];

  rnd_decide u_decide (
    .mode    (mode),
    .sign    (sign_i),
    .guard   (guard),
    .rbit    (rbit),
    .sticky  (sticky_i),
    .lsb     (trunc[0]),
    .inc     (inc),
    .inexact (inexact)
  );

  rnd_ovf_policy u_ovf (
    .mode   (mode),
    .sign   (sign_i),
    .to_inf (to_inf)
  );

  rnd_incr #(.W(MANT_W)) u_incr (
    .a    (trunc),
    .cin  (inc),
    .sum  (sum),
    .cout (cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mant_o       <= '0;
      carry_o      <= 1'b0;
      rounded_up_o <= 1'b0;
      inexact_o    <= 1'b0;
      ovf_inf_o    <= 1'b0;
    end else begin
      mant_o       <= sum;
      carry_o      <= cout;
      rounded_up_o <= inc;
      inexact_o    <= inexact;
      ovf_inf_o    <= to_inf;
    end
  end

endmodule

// File: rtl/mant_rounder_chk.sv
module mant_rounder_chk #(
  parameter int MANT_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              sign_i,
  input logic [1:0]        mode_i,
  input logic [MANT_W+1:0] mant_i,
  input logic              sticky_i,
  input logic [MANT_W-1:0] mant_o,
  input logic              carry_o,
  input logic              rounded_up_o,
  input logic              inexact_o,
  input logic              ovf_inf_o
);

  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (mant_o == '0 && !carry_o && !rounded_up_o && !inexact_o && !ovf_inf_o));

  p_exact_r2: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(mant_i[1:0]) == 2'b00 && !$past(sticky_i))
      |-> (mant_o == $past(mant_i[MANT_W+1:2]) && !inexact_o && !rounded_up_o && !carry_o));

  p_inexact_r3: assert property (@(posedge clk) disable iff (rst)
    seen |-> (inexact_o == ($past(mant_i[1]) | $past(mant_i[0]) | $past(sticky_i))));

  p_near_guard_r4: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(mode_i) == 2'b00 && !$past(mant_i[1])) |-> !rounded_up_o);

  p_tie_even_r5: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(mode_i) == 2'b00 && $past(mant_i[2:0]) == 3'b010 && !$past(sticky_i))
      |-> !rounded_up_o);

  p_zero_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(mode_i) == 2'b01) |-> !rounded_up_o);

  p_dir_sign_r7: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(mode_i[1]) && ($past(mode_i[0]) != $past(sign_i))) |-> !rounded_up_o);

  p_carry_r8: assert property (@(posedge clk) disable iff (rst)
    carry_o |-> (rounded_up_o && mant_o == '0));

  p_sum_r8: assert property (@(posedge clk) disable iff (rst)
    seen |-> ({carry_o, mant_o} ==
              ({1'b0, $past(mant_i[MANT_W+1:2])} + {{MANT_W{1'b0}}, rounded_up_o})));

  p_ovf_near_r9: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(mode_i) == 2'b00) |-> ovf_inf_o);

  p_ovf_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(mode_i) == 2'b01) |-> !ovf_inf_o);

endmodule

bind mant_rounder mant_rounder_chk #(.MANT_W(MANT_W)) u_chk (.*);

// File: tb/mant_rounder_test.sv
`timescale 1ns/1ps
module mant_rounder_test;

  localparam int MW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sign_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [MW+1:0] mant_i = '0;
  logic          sticky_i = 1'b0;
  logic [MW-1:0] mant_o;
  logic          carry_o, rounded_up_o, inexact_o, ovf_inf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mant_rounder #(.MANT_W(MW)) uut (
    .clk(clk), .rst(rst), .sign_i(sign_i), .mode_i(mode_i), .mant_i(mant_i),
    .sticky_i(sticky_i), .mant_o(mant_o), .carry_o(carry_o),
    .rounded_up_o(rounded_up_o), .inexact_o(inexact_o), .ovf_inf_o(ovf_inf_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d sign %0d mant %0h sticky %0d)",
               tag, act, exp, mode_i, sign_i, mant_i, sticky_i);
    end
  endtask

  // Expected values from the requirements.
  int e_sum, e_up, e_inex, e_ovf;
  string up_tag;
  task automatic model(input int m, input int s, input int md, input int st);
    int tr, g, r, lsb;
    tr = m >> 2; g = (m >> 1) & 1; r = m & 1; lsb = tr & 1;
    e_inex = (g | r | st);
    case (md)
      0: begin
        if (!g)            begin e_up = 0;   up_tag = "R4"; end
        else if (r || st)  begin e_up = 1;   up_tag = "R4"; end
        else               begin e_up = lsb; up_tag = "R5"; end
      end
      1: begin e_up = 0; up_tag = "R6"; end
      2: begin e_up = e_inex & (s == 0); up_tag = "R7"; end
      default: begin e_up = e_inex & (s == 1); up_tag = "R7"; end
    endcase
    e_sum = tr + e_up;
    e_ovf = (md == 0) ? 1 : (md == 1) ? 0 : (md == 2) ? (s == 0) : s;
  endtask

  task automatic check_all(input int m, input int s, input int md, input int st);
    model(m, s, md, st);
    if (e_inex == 0) check("R2", int'(mant_o), m >> 2);
    check("R8", int'({carry_o, mant_o}), e_sum);
    check("R8", int'(carry_o), (e_sum >> MW) & 1);
    check(up_tag, int'(rounded_up_o), e_up);
    check("R3", int'(inexact_o), e_inex);
    check("R9", int'(ovf_inf_o), e_ovf);
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset clears outputs even with active inputs.
    mant_i = '1; sticky_i = 1'b1; mode_i = 2'b10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'({mant_o, carry_o, rounded_up_o, inexact_o, ovf_inf_o}), 0);
    rst = 1'b0;

    // Full sweep: every mode, sign, mantissa (guard/round/LSB/all-ones) and sticky.
    for (int md = 0; md < 4; md++)
      for (int s = 0; s < 2; s++)
        for (int m = 0; m < (1 << (MW + 2)); m++)
          for (int st = 0; st < 2; st++) begin
            @(negedge clk);
            mode_i = md[1:0]; sign_i = s[0]; mant_i = m[MW+1:0]; sticky_i = st[0];
            @(negedge clk);
            check_all(m, s, md, st);
          end

    // R8: explicit all-ones carry case in toward-plus mode.
    @(negedge clk);
    mode_i = 2'b10; sign_i = 1'b0; mant_i = '1; sticky_i = 1'b0;
    @(negedge clk);
    check("R8", int'(carry_o), 1);
    check("R8", int'(mant_o), 0);

    // R10: new inputs do not show before the next rising edge.
    mode_i = 2'b01; sign_i = 1'b0; mant_i = 8'h05; sticky_i = 1'b0;
    #1;
    check("R10", int'(carry_o), 1);
    check("R10", int'(ovf_inf_o), 1);
    @(negedge clk);
    check("R10", int'(mant_o), 1);
    check("R10", int'(ovf_inf_o), 0);

    // R1: mid-run reset.
    rst = 1'b1;
    @(negedge clk);
    check("R1", int'({mant_o, carry_o, rounded_up_o, inexact_o, ovf_inf_o}), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule